// File: doc/BRIEF.md
# Dual-Mode Serial Output Port for Demodulated Bytes

This block hands characters recovered by an FSK receiver to a host over three lines: a bit clock, a serial data line and an active-low ready strobe. A character arrives as a parallel byte qualified by a one-cycle valid pulse. The block shifts each character out least significant bit first. The data line changes while the bit clock is low, so the host samples on the rising edge.

Two ways of working are selectable. In push mode the block begins each transfer itself. It lowers the ready strobe, then generates eight clock pulses whose half-period is a parameterised number of system clocks, then raises the strobe again. In pull mode the host drives the bit clock. That clock is brought into the system domain through a two-flop synchroniser and an edge detector. The block holds the strobe low until the host has produced eight rising edges. An unread byte that is overwritten raises a sticky overrun flag.

An active-low, already qualified carrier-present input gates the whole port. While the carrier is absent, received bytes are discarded. Push mode then holds all three lines high, and pull mode keeps the strobe high and loads nothing.

Top module: `fsk_serial_port`

## Requirements
- R1: After synchronous reset, `dclk_o`, `data_o` and `ready_n` are high and `overrun` is low.
- R2: In push mode (`mode_sel`=0) with `carrier_n` high, a `rx_valid` pulse is discarded. `dclk_o`, `data_o` and `ready_n` all stay high.
- R3: In push mode with carrier present and no transfer running, a `rx_valid` pulse is accepted at that clock edge, and `ready_n` is low from the next cycle.
- R4: A push transfer produces exactly eight rising edges on `dclk_o`. Each half period lasts DIV system clocks, and the first falling edge comes DIV cycles after `ready_n` falls. `data_o` changes only as `dclk_o` falls, and the bit values seen at the eight rising edges are the byte, bit 0 first.
- R5: In push mode, `ready_n` stays low for exactly 17*DIV cycles. After that, `ready_n`, `dclk_o` and `data_o` are all high.
- R6: In push mode, a `rx_valid` pulse that arrives while a transfer is running is dropped. The running byte completes unchanged and no second transfer follows.
- R7: In push mode, losing the carrier during a transfer returns all three lines high in the next cycle.
- R8: In pull mode (`mode_sel`=1), `dclk_o` stays high. An accepted byte drives `ready_n` low and presents bit 0 on `data_o` in the next cycle.
- R9: In pull mode, each falling edge of `host_clk` after the first rising edge moves `data_o` to the next bit, LSB first. `ready_n` returns high after the eighth rising edge of `host_clk`. Both take effect three system clocks after the `host_clk` change.
- R10: In pull mode, a byte accepted while `ready_n` is low replaces the pending byte and sets `overrun`. Only reset clears `overrun`.
- R11: In pull mode with `carrier_n` high, `rx_valid` loads nothing and `ready_n` is high. A pending byte is dropped one cycle after the carrier goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | 0 = block-clocked push, 1 = host-clocked pull |
| carrier_n | input | 1 | Qualified carrier present, active low |
| rx_byte | input | DATA_W | Received character |
| rx_valid | input | 1 | One-cycle strobe for `rx_byte` |
| host_clk | input | 1 | Bit clock from the host in pull mode, idles high |
| dclk_o | output | 1 | Bit clock generated in push mode, high otherwise |
| data_o | output | 1 | Serial data, LSB first |
| ready_n | output | 1 | Data-ready strobe, active low |
| overrun | output | 1 | Sticky flag: a pending pull-mode byte was overwritten |

## Verification
The hardest case to reach is an overwrite in pull mode. A second byte must land while the host has not finished the first one. The stimulus therefore loads one byte and, with no `host_clk` activity, loads another at once. It then clocks out all eight bits and checks that they belong to the second byte. A later clean transfer shows that `overrun` stays set. Carrier loss during a push transfer is reached by dropping `carrier_n` partway through the bit clocks.

// File: rtl/fsk_port_pkg.sv
package fsk_port_pkg;

    typedef enum logic {
        MODE_PUSH = 1'b0,
        MODE_PULL = 1'b1
    } port_mode_e;

    // State of the three output lines
    typedef struct packed {
        logic dclk;
        logic data;
        logic rdy_n;
    } wire3_t;

    localparam wire3_t WIRE3_IDLE = '{dclk: 1'b1, data: 1'b1, rdy_n: 1'b1};

    function automatic logic half_goes_low(input logic cur_half_lsb);
        // an even half-period index hands over to a low phase
        return ~cur_half_lsb;
    endfunction

endpackage

// File: rtl/fsk_edge_sync.sv
module fsk_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= async_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;
    assign fall = ~s2 & s3;
endmodule

// File: rtl/fsk_push_tx.sv
module fsk_push_tx
    import fsk_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              carrier_ok,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output wire3_t            lines
);
    localparam int HALVES = 2 * DATA_W;
    localparam int HW     = $clog2(HALVES + 1);
    localparam int TW     = (DIV > 1) ? $clog2(DIV) : 1;

    logic              busy;
    logic [HW-1:0]     hc;
    logic [TW-1:0]     tick;
    logic [DATA_W-1:0] sh;
    wire3_t            out_q;

    always_ff @(posedge clk) begin
        if (rst || !en || !carrier_ok) begin
            busy  <= 1'b0;
            hc    <= '0;
            tick  <= '0;
            sh    <= '0;
            out_q <= WIRE3_IDLE;
        end else if (!busy) begin
            if (load) begin
                busy        <= 1'b1;
                sh          <= din;
                hc          <= '0;
                tick        <= '0;
                out_q.rdy_n <= 1'b0;
            end
        end else if (tick == TW'(DIV - 1)) begin
            tick <= '0;
            if (hc == HW'(HALVES)) begin
                busy  <= 1'b0;
                out_q <= WIRE3_IDLE;
            end else begin
                hc         <= hc + 1'b1;
                out_q.dclk <= hc[0];
                if (half_goes_low(hc[0])) begin
                    out_q.data <= sh[0];
                    sh         <= sh >> 1;
                end
            end
        end else begin
            tick <= tick + 1'b1;
        end
    end

    assign lines = out_q;
endmodule

// File: rtl/fsk_pull_tx.sv
module fsk_pull_tx
    import fsk_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              carrier_ok,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              hrise,
    input  logic              hfall,
    output wire3_t            lines,
    output logic              ovr
);
    localparam int CW = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] sh;
    logic [CW-1:0]     cnt;
    logic              rdy_n_q;
    logic              data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            cnt     <= '0;
            rdy_n_q <= 1'b1;
            data_q  <= 1'b1;
            ovr     <= 1'b0;
        end else if (!en || !carrier_ok) begin
            rdy_n_q <= 1'b1;
            cnt     <= '0;
        end else if (load) begin
            sh      <= din;
            data_q  <= din[0];
            cnt     <= '0;
            rdy_n_q <= 1'b0;
            if (!rdy_n_q) ovr <= 1'b1;
        end else if (!rdy_n_q) begin
            if (hrise) begin
                cnt <= cnt + 1'b1;
                if (cnt == CW'(DATA_W - 1)) rdy_n_q <= 1'b1;
            end else if (hfall && cnt != '0) begin
                sh     <= sh >> 1;
                data_q <= sh[1];
            end
        end
    end

    assign lines = '{dclk: 1'b1, data: data_q, rdy_n: rdy_n_q};
endmodule

// File: rtl/fsk_serial_port.sv
module fsk_serial_port
    import fsk_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sel,
    input  logic              carrier_n,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic              host_clk,
    output logic              dclk_o,
    output logic              data_o,
    output logic              ready_n,
    output logic              overrun
);
    port_mode_e mode;
    wire3_t     push_l, pull_l, sel_l;
    logic       hrise, hfall;

    assign mode = port_mode_e'(mode_sel);

    fsk_edge_sync u_sync (
        .clk(clk), .rst(rst), .async_in(host_clk),
        .rise(hrise), .fall(hfall)
    );

    fsk_push_tx #(.DATA_W(DATA_W), .DIV(DIV)) u_push (
        .clk(clk), .rst(rst), .en(mode == MODE_PUSH),
        .carrier_ok(~carrier_n), .load(rx_valid), .din(rx_byte),
        .lines(push_l)
    );

    fsk_pull_tx #(.DATA_W(DATA_W)) u_pull (
        .clk(clk), .rst(rst), .en(mode == MODE_PULL),
        .carrier_ok(~carrier_n), .load(rx_valid), .din(rx_byte),
        .hrise(hrise), .hfall(hfall), .lines(pull_l), .ovr(overrun)
    );

    assign sel_l   = (mode == MODE_PUSH) ? push_l : pull_l;
    assign dclk_o  = sel_l.dclk;
    assign data_o  = sel_l.data;
    assign ready_n = sel_l.rdy_n;
endmodule

// File: rtl/fsk_serial_port_chk.sv
module fsk_serial_port_chk (
    input logic clk,
    input logic rst,
    input logic mode_sel,
    input logic carrier_n,
    input logic rx_valid,
    input logic dclk_o,
    input logic data_o,
    input logic ready_n,
    input logic overrun
);
    AST_PUSH_IDLE_NO_CARRIER: assert property (@(posedge clk) disable iff (rst)
        (!mode_sel && !$past(mode_sel) && carrier_n && $past(carrier_n))
        |-> (dclk_o && data_o && ready_n)); // R2

    AST_DCLK_QUIET_WHEN_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (ready_n && $past(ready_n)) |-> dclk_o); // R4

    AST_PUSH_DATA_HOLDS_HIGH_CLK: assert property (@(posedge clk) disable iff (rst)
        (!mode_sel && !$past(mode_sel) && !carrier_n && !$past(carrier_n)
         && dclk_o && $past(dclk_o) && !ready_n && !$past(ready_n))
        |-> $stable(data_o)); // R4

    AST_PULL_NO_READY_NO_CARRIER: assert property (@(posedge clk) disable iff (rst)
        (mode_sel && $past(mode_sel) && carrier_n && $past(carrier_n)) |-> ready_n); // R11

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R10

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(rx_valid && !carrier_n && mode_sel && !ready_n)); // R10
endmodule

bind fsk_serial_port fsk_serial_port_chk u_chk (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .carrier_n(carrier_n),
    .rx_valid(rx_valid), .dclk_o(dclk_o), .data_o(data_o),
    .ready_n(ready_n), .overrun(overrun)
);

// File: tb/fsk_serial_port_test.sv
module fsk_serial_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 3;
    localparam int NVEC       = 8;
    // each entry: {mode, byte}
    localparam logic [8:0] VEC [NVEC] = '{
        9'h0A5, 9'h001, 9'h080, 9'h0FF, 9'h100, 9'h1C3, 9'h17E, 9'h15A
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_sel = 1'b0;
    logic       carrier_n = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_valid = 1'b0;
    logic       host_clk = 1'b1;
    logic       dclk_o, data_o, ready_n, overrun;

    int n_chk = 0;
    int n_bad = 0;

    fsk_serial_port #(.DATA_W(8), .DIV(DIV)) uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .carrier_n(carrier_n),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .host_clk(host_clk),
        .dclk_o(dclk_o), .data_o(data_o), .ready_n(ready_n), .overrun(overrun)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lines_high(input string req);
        chk(req, {29'd0, dclk_o, data_o, ready_n}, 7);
    endtask

    task automatic push_byte(input logic [7:0] b, input bit inject);
        int low_cnt, rises;
        logic [7:0] got;
        logic pd;
        @(negedge clk); rx_byte = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        chk("R3 ready low after accept", ready_n, 0);
        low_cnt = 1; rises = 0; got = '0; pd = dclk_o;
        while (!ready_n && low_cnt < 1000) begin
            @(negedge clk);
            if (!pd && dclk_o) begin
                if (rises < 8) got[rises] = data_o;
                rises++;
            end
            if (!ready_n) low_cnt++;
            pd = dclk_o;
            if (inject && low_cnt == 5) begin
                rx_byte = ~b; rx_valid = 1'b1;
            end else begin
                rx_valid = 1'b0;
            end
        end
        rx_valid = 1'b0;
        chk("R4 rising clock count", rises, 8);
        chk("R4 serial bits LSB first", got, b);
        chk("R5 ready low duration", low_cnt, 17 * DIV);
        lines_high("R5 lines high after transfer");
        if (inject) begin
            int low_seen = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (!ready_n) low_seen++;
            end
            chk("R6 dropped byte starts no transfer", low_seen, 0);
        end
    endtask

    task automatic pull_byte(input logic [7:0] b);
        @(negedge clk); rx_byte = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        chk("R8 ready low after load", ready_n, 0);
        chk("R8 bit0 presented", data_o, b[0]);
        chk("R8 dclk_o high in pull", dclk_o, 1);
        for (int i = 0; i < 8; i++) begin
            host_clk = 1'b0;
            repeat (4) @(negedge clk);
            chk("R9 pull bit value", data_o, b[i]);
            if (i == 7) chk("R9 ready low before last rise", ready_n, 0);
            host_clk = 1'b1;
            repeat (4) @(negedge clk);
        end
        chk("R9 ready released after eighth rise", ready_n, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        lines_high("R1 idle lines after reset");
        chk("R1 overrun clear", overrun, 0);

        // table-driven transfers in both modes
        for (int v = 0; v < NVEC; v++) begin
            mode_sel = VEC[v][8];
            repeat (2) @(negedge clk);
            if (!VEC[v][8]) push_byte(VEC[v][7:0], 1'b0);
            else            pull_byte(VEC[v][7:0]);
        end
        chk("R10 no overrun after clean reads", overrun, 0);

        // R2: push mode, no carrier
        mode_sel = 1'b0; carrier_n = 1'b1;
        repeat (2) @(negedge clk);
        rx_byte = 8'h3C; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        begin
            int bad = 0;
            for (int k = 0; k < 20; k++) begin
                if (!(dclk_o && data_o && ready_n)) bad++;
                @(negedge clk);
            end
            chk("R2 lines stay high without carrier", bad, 0);
        end
        carrier_n = 1'b0;
        repeat (2) @(negedge clk);

        // R6: byte arriving mid-transfer is dropped
        push_byte(8'h96, 1'b1);

        // R7: carrier loss aborts push transfer
        @(negedge clk); rx_byte = 8'h00; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        repeat (4 * DIV) @(negedge clk);
        chk("R7 transfer running before carrier loss", ready_n, 0);
        carrier_n = 1'b1;
        @(negedge clk);
        lines_high("R7 idle right after carrier loss");
        carrier_n = 1'b0;
        repeat (3) @(negedge clk);

        // R11: pull mode without carrier
        mode_sel = 1'b1;
        repeat (2) @(negedge clk);
        carrier_n = 1'b1;
        @(negedge clk); rx_byte = 8'h44; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        chk("R11 no load without carrier", ready_n, 1);
        carrier_n = 1'b0;
        @(negedge clk); rx_byte = 8'h21; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        chk("R11 pending byte before carrier loss", ready_n, 0);
        carrier_n = 1'b1;
        @(negedge clk);
        chk("R11 pending byte dropped", ready_n, 1);
        carrier_n = 1'b0;
        repeat (2) @(negedge clk);

        // R10: overwrite of an unread byte
        @(negedge clk); rx_byte = 8'h11; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
        chk("R10 no overrun on first byte", overrun, 0);
        pull_byte(8'hB4);
        chk("R10 overrun set by overwrite", overrun, 1);
        pull_byte(8'h5A);
        chk("R10 overrun sticky", overrun, 1);

        // R1: reset clears sticky flag
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; mode_sel = 1'b0;
        @(negedge clk);
        chk("R1 overrun cleared by reset", overrun, 0);
        lines_high("R1 idle lines after second reset");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule